// File: doc/BRIEF.md
# Barrel-Thread Issue Scheduler with Replay

This block decides which hardware thread issues into a deep in-order pipeline on each cycle. The threads take turns in a fixed rotation, one thread per cycle. The pipeline never stalls. Each thread owns a program counter pair: the current PC and the next PC. The scheduler presents the pair of the thread whose turn it is. Fine-grain interleaving of many threads hides the hazard gaps, so the pipeline needs no bypass network.

The back end reports each instruction's outcome together with its thread id. A commit advances that thread's PC pair, either sequentially or to a branch target. A replay leaves the pair untouched, so the same instruction issues again on the thread's next turn. The memory side can mark a thread as waiting on a refill and later release it. A waiting thread issues a bubble in its own slot, and the slot is never handed to another thread. The thread count is a parameter, normally 32 or 64.

Top module: `rr_replay_issue`

## Requirements
- R1: After reset the issue slot shows thread 0, and every thread is ready (not waiting) with PC = RESET_VEC and next PC = RESET_VEC+4.
- R2: The issued thread id advances by one each cycle and wraps from NTHR-1 to 0, whatever the other inputs do.
- R3: A commit without a taken transfer (fb_valid=1, fb_replay=0, fb_taken=0) sets the reported thread's PC to its old next PC, and its next PC to the old next PC plus 4.
- R4: A taken commit (fb_valid=1, fb_replay=0, fb_taken=1) sets the thread's PC to its old next PC, and its next PC to fb_target.
- R5: A replay (fb_valid=1, fb_replay=1) leaves the thread's PC and next PC unchanged, so the same PC issues on that thread's next turn.
- R6: Feedback changes only the state of the thread named by fb_tid. With fb_valid=0 no PC state changes.
- R7: A thread whose bit in mem_wait was raised issues with iss_valid=0 in its slot until it is released, and iss_tid still names that thread.
- R8: A mem_ready bit releases a waiting thread from the next cycle on. When mem_wait and mem_ready are both high for the same thread, the thread waits.
- R9: iss_pc and iss_npc always show the current PC pair of the thread named by iss_tid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_wait | input | NTHR | Per-thread flag: the thread starts waiting on a refill |
| mem_ready | input | NTHR | Per-thread flag: the thread's refill is done |
| fb_valid | input | 1 | Back-end feedback is present |
| fb_replay | input | 1 | 1 = replay, 0 = commit |
| fb_tid | input | $clog2(NTHR) | Thread the feedback belongs to |
| fb_taken | input | 1 | The commit is a taken control transfer |
| fb_target | input | AW | Target of a taken transfer |
| iss_valid | output | 1 | 1 = issue, 0 = bubble in this slot |
| iss_tid | output | $clog2(NTHR) | Thread that owns this slot |
| iss_pc | output | AW | PC of the issuing thread |
| iss_npc | output | AW | Next PC of the issuing thread |

## Verification
A corrupted PC pair stays hidden until its thread comes round again. That is up to NTHR cycles after the faulty update. The pair then appears in full on iss_pc and iss_npc, and every later turn repeats the error. A wrong rotation pointer or wait bit shows at once, on iss_tid or iss_valid in the very next slot. The bench therefore keeps a model of every thread's pair and wait state, and compares them on every slot across many full rotations.

// File: rtl/rr_replay_issue.sv
module rr_replay_issue #(
  parameter int NTHR = 32,
  parameter int AW   = 32,
  parameter logic [AW-1:0] RESET_VEC = '0,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] mem_wait,
  input  logic [NTHR-1:0] mem_ready,
  input  logic            fb_valid,
  input  logic            fb_replay,
  input  logic [TW-1:0]   fb_tid,
  input  logic            fb_taken,
  input  logic [AW-1:0]   fb_target,
  output logic            iss_valid,
  output logic [TW-1:0]   iss_tid,
  output logic [AW-1:0]   iss_pc,
  output logic [AW-1:0]   iss_npc
);

  localparam logic [TW-1:0] LAST = TW'(NTHR - 1);

  logic [TW-1:0]             ptr;
  logic [NTHR-1:0]           waiting;
  logic [NTHR-1:0][AW-1:0]   pc_q;
  logic [NTHR-1:0][AW-1:0]   npc_q;

  wire commit = fb_valid && !fb_replay;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      waiting <= '0;
      for (int i = 0; i < NTHR; i++) begin
        pc_q[i]  <= RESET_VEC;
        npc_q[i] <= RESET_VEC + AW'(4);
      end
    end else begin
      ptr     <= (ptr == LAST) ? '0 : ptr + TW'(1);
      waiting <= (waiting & ~mem_ready) | mem_wait;
      if (commit) begin
        pc_q[fb_tid]  <= npc_q[fb_tid];
        npc_q[fb_tid] <= fb_taken ? fb_target : npc_q[fb_tid] + AW'(4);
      end
    end
  end

  assign iss_tid   = ptr;
  assign iss_valid = ~waiting[ptr];
  assign iss_pc    = pc_q[ptr];
  assign iss_npc   = npc_q[ptr];

endmodule

// File: rtl/rr_replay_issue_chk.sv
module rr_replay_issue_chk #(
  parameter int NTHR = 32,
  parameter int AW   = 32,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NTHR-1:0]         mem_wait,
  input logic [NTHR-1:0]         mem_ready,
  input logic                    fb_valid,
  input logic                    fb_replay,
  input logic [TW-1:0]           fb_tid,
  input logic                    fb_taken,
  input logic [AW-1:0]           fb_target,
  input logic                    iss_valid,
  input logic [TW-1:0]           iss_tid,
  input logic [NTHR-1:0][AW-1:0] pc_q,
  input logic [NTHR-1:0][AW-1:0] npc_q
);
  logic started;
  logic [TW-1:0] nxt;
  assign nxt = (iss_tid == TW'(NTHR - 1)) ? '0 : iss_tid + TW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  a_r1_reset_slot: assert property (@(posedge clk)
    (rst_n && !started) |-> (iss_tid == '0 && iss_valid));

  a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> (iss_tid == ((($past(iss_tid) == TW'(NTHR - 1))) ? '0 : $past(iss_tid) + TW'(1))));

  a_r3_commit_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (started && fb_valid && !fb_replay && !fb_taken) |=>
      (pc_q[$past(fb_tid)] == $past(npc_q[fb_tid]) &&
       npc_q[$past(fb_tid)] == $past(npc_q[fb_tid]) + AW'(4)));

  a_r4_commit_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (started && fb_valid && !fb_replay && fb_taken) |=>
      (pc_q[$past(fb_tid)] == $past(npc_q[fb_tid]) &&
       npc_q[$past(fb_tid)] == $past(fb_target)));

  a_r5_replay_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (started && fb_valid && fb_replay) |=>
      (pc_q[$past(fb_tid)] == $past(pc_q[fb_tid]) &&
       npc_q[$past(fb_tid)] == $past(npc_q[fb_tid])));

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !fb_valid) |=> (pc_q == $past(pc_q) && npc_q == $past(npc_q)));

  a_r7_wait_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mem_wait[nxt]) |=> !iss_valid);

  a_r8_ready_release: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mem_ready[nxt] && !mem_wait[nxt]) |=> iss_valid);
endmodule

bind rr_replay_issue rr_replay_issue_chk #(.NTHR(NTHR), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_wait(mem_wait), .mem_ready(mem_ready),
  .fb_valid(fb_valid), .fb_replay(fb_replay), .fb_tid(fb_tid),
  .fb_taken(fb_taken), .fb_target(fb_target), .iss_valid(iss_valid),
  .iss_tid(iss_tid), .pc_q(pc_q), .npc_q(npc_q)
);

// File: tb/rr_replay_issue_bench.sv
`timescale 1ns/1ps
module rr_replay_issue_bench;
  localparam int NTHR = 32;
  localparam int AW   = 32;
  localparam int TW   = $clog2(NTHR);
  localparam logic [AW-1:0] RV = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NTHR-1:0] mem_wait = '0, mem_ready = '0;
  logic fb_valid = 1'b0, fb_replay = 1'b0, fb_taken = 1'b0;
  logic [TW-1:0] fb_tid = '0;
  logic [AW-1:0] fb_target = '0;
  logic iss_valid;
  logic [TW-1:0] iss_tid;
  logic [AW-1:0] iss_pc, iss_npc;

  always #2.5 clk = ~clk;

  rr_replay_issue #(.NTHR(NTHR), .AW(AW), .RESET_VEC(RV)) u_rr_replay_issue (
    .clk(clk), .rst_n(rst_n), .mem_wait(mem_wait), .mem_ready(mem_ready),
    .fb_valid(fb_valid), .fb_replay(fb_replay), .fb_tid(fb_tid),
    .fb_taken(fb_taken), .fb_target(fb_target), .iss_valid(iss_valid),
    .iss_tid(iss_tid), .iss_pc(iss_pc), .iss_npc(iss_npc));

  int checks = 0, fails = 0;
  logic [AW-1:0] mpc [NTHR];
  logic [AW-1:0] mnpc [NTHR];
  logic mwait [NTHR];
  int mtid = 0;

  function automatic int next_tid(int t);
    return (t == NTHR - 1) ? 0 : t + 1;
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_slot(string lab);
    chk({"R2 ", lab}, AW'(iss_tid), AW'(mtid));
    chk({"R7 ", lab}, AW'(iss_valid), AW'(!mwait[mtid]));
    chk({"R9 ", lab}, iss_pc, mpc[mtid]);
    chk({"R9 ", lab}, iss_npc, mnpc[mtid]);
  endtask

  task automatic tick(logic [NTHR-1:0] w, logic [NTHR-1:0] r, logic v, logic rep,
                      int t, logic tk, logic [AW-1:0] tg, string lab);
    mem_wait = w; mem_ready = r; fb_valid = v; fb_replay = rep;
    fb_tid = TW'(t); fb_taken = tk; fb_target = tg;
    if (v && !rep) begin
      mpc[t] = mnpc[t];
      mnpc[t] = tk ? tg : mnpc[t] + 32'd4;
    end
    for (int i = 0; i < NTHR; i++) mwait[i] = (mwait[i] && !r[i]) || w[i];
    mtid = next_tid(mtid);
    @(negedge clk);
    check_slot(lab);
  endtask

  task automatic idle(string lab);
    tick('0, '0, 1'b0, 1'b0, 0, 1'b0, '0, lab);
  endtask

  task automatic run_to(int t, string lab);
    while (next_tid(mtid) != t) idle(lab);
    idle(lab);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NTHR; i++) begin
      mpc[i] = RV; mnpc[i] = RV + 32'd4; mwait[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check_slot("R1 reset slot 0");
    chk("R1 reset tid", AW'(iss_tid), '0);
    chk("R1 reset ready", AW'(iss_valid), 1);
    for (int i = 1; i < NTHR; i++) idle("R1 reset pcs");
    idle("R2 wrap to 0");
    chk("R2 wrap", AW'(iss_tid), '0);

    // R3 sequential commit on thread 5, seen on its next turn
    run_to(4, "R3 setup");
    tick('0, '0, 1'b1, 1'b0, 5, 1'b0, '0, "R3 commit");
    run_to(5, "R3 observe");
    chk("R3 pc", iss_pc, RV + 32'd4);
    chk("R3 npc", iss_npc, RV + 32'd8);

    // R4 taken commit on thread 7
    tick('0, '0, 1'b1, 1'b0, 7, 1'b1, 32'h0000_8000, "R4 commit");
    run_to(7, "R4 observe");
    chk("R4 pc", iss_pc, RV + 32'd4);
    chk("R4 npc", iss_npc, 32'h0000_8000);

    // R5 replay on thread 5 keeps PC; R6 other threads untouched
    tick('0, '0, 1'b1, 1'b1, 5, 1'b1, 32'hDEAD_0000, "R5 replay");
    run_to(5, "R5 observe");
    chk("R5 pc", iss_pc, RV + 32'd4);
    chk("R5 npc", iss_npc, RV + 32'd8);
    run_to(6, "R6 observe");
    chk("R6 untouched pc", iss_pc, RV);

    // R7 wait bubbles, R8 simultaneous wait+ready keeps waiting, then release
    tick(NTHR'(1) << 9, '0, 1'b0, 1'b0, 0, 1'b0, '0, "R7 set wait");
    run_to(9, "R7 observe");
    chk("R7 bubble", AW'(iss_valid), 0);
    chk("R7 slot kept", AW'(iss_tid), 9);
    tick(NTHR'(1) << 9, NTHR'(1) << 9, 1'b0, 1'b0, 0, 1'b0, '0, "R8 both");
    run_to(9, "R8 observe both");
    chk("R8 wait wins", AW'(iss_valid), 0);
    tick('0, NTHR'(1) << 9, 1'b0, 1'b0, 0, 1'b0, '0, "R8 release");
    run_to(9, "R8 observe release");
    chk("R8 released", AW'(iss_valid), 1);

    // random phase covering R3 R4 R5 R6 R7 R8 together
    for (int n = 0; n < 20000; n++) begin
      logic [NTHR-1:0] w, r;
      w = '0; r = '0;
      for (int i = 0; i < NTHR; i++) begin
        w[i] = ($urandom % 64) == 0;
        r[i] = ($urandom % 8) == 0;
      end
      tick(w, r, ($urandom % 4) != 0, ($urandom % 3) == 0, int'($urandom % NTHR),
           ($urandom % 3) == 0, $urandom & 32'hFFFF_FFFC, "R6 random");
    end
    finish_run();
  end
endmodule